// File: doc/BRIEF.md
# Triggered Capture and Playback Sample Buffer

This block controls a 2048-entry buffer of complex (I,Q) samples. When armed for capture, it waits for a trigger and then skips a programmable number of valid samples. It then records a programmable number of samples from one of three points in the signal chain: the stream before predistortion, the stream after predistortion, or the magnitude value. When armed for playback, it streams entries the processor has preloaded out of the buffer, one per clock, as stimulus.

The trigger comes from one of three sources: an external input, a magnitude-window detector that fires when a valid sample's magnitude leaves the programmed [min, max] window, or a self-clearing software bit. A one-cycle trigger-out pulse marks the point where the capture sequence starts.

A processor configures the block through a small register file. It reaches the buffer through a pointer register and a data register, and the pointer advances by one after every data access. Register map (3-bit address): 0 control/status, 1 delay, 2 length, 3 magnitude max, 4 magnitude min, 5 pointer, 6 data.

Top module: `trig_capture_buf`

## Requirements
- R1: After a synchronous reset, trig_out and play_valid are 0, the control register reads 0 (not busy, not done) and the pointer reads 0.
- R2: A write to register 5 loads the buffer pointer. A write to register 6 stores {Q in bits 31:16, I in bits 15:0} at the pointer. A read of register 6 returns that entry on reg_rdata in the following cycle. Both data accesses advance the pointer by one, and the pointer wraps from 2047 to 0.
- R3: Control bits [5:4] select the trigger: 0 external input, 1 magnitude window, 2 software bit, 3 none. An unselected source never fires.
- R4: With the magnitude trigger selected, a valid sample whose magnitude is above the max register or below the min register fires the trigger. Samples inside the window, and invalid samples, do not fire it.
- R5: Writing 1 to control bit 6 issues a single software trigger. The bit always reads back as 0.
- R6: After a trigger, the first D valid samples (D = delay register bits 14:0) are discarded. The sample that arrives in the trigger cycle is not counted.
- R7: Capture writes the next L+1 valid samples (L = length register bits 10:0) to entries 0..L. Entries above L keep their contents.
- R8: Control bits [3:2] select the captured word: 0 pre-distortion {Q,I}, 1 post-distortion {Q,I}, 2 magnitude in I with Q = 0.
- R9: trig_out is high for exactly the one cycle that follows the clock edge at which a trigger is accepted.
- R10: A trigger that arrives while the block is delaying or capturing is ignored. It causes no second trig_out pulse and no restart.
- R11: Writing control with bit 0 (arm) = 1 and bit 1 (mode) = 1 plays entries 0..L on consecutive cycles. play_valid is high for exactly L+1 cycles.
- R12: Control bit 8 (done) is set when the length count expires and cleared by the next arm. Control bit 9 (busy) is high from arm to completion.
- R13: While busy, data-register (register 6) accesses are ignored: nothing is written and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe for the input stream |
| pre_i | input | 16 | Pre-distortion I sample |
| pre_q | input | 16 | Pre-distortion Q sample |
| post_i | input | 16 | Post-distortion I sample |
| post_q | input | 16 | Post-distortion Q sample |
| mag | input | 16 | Magnitude of the current sample |
| ext_trig | input | 1 | External trigger input |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| trig_out | output | 1 | One-cycle pulse when a trigger is accepted |
| play_valid | output | 1 | Playback sample valid |
| play_i | output | 16 | Playback I |
| play_q | output | 16 | Playback Q |

## Verification
Each sample carries a distinct, index-derived value, so any capture window that is off by one sample in either direction produces a mismatch. Capture is exercised with the external, below-minimum, above-maximum and software triggers. The source select is run at each of its three settings, and the delay at zero, one and three. Valid strobes dropped during the delay and capture phases show that only valid samples are counted. Extra triggers injected mid-capture distinguish correct ignoring from a restart. Playback of a preloaded pattern, together with a data write attempted during it and a read across the pointer wrap, separates the two users of the buffer port.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_DLY, S_CAP, S_PLAY
  } seq_state_t;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_DELAY = 3'd1;
  localparam logic [2:0] RA_LEN   = 3'd2;
  localparam logic [2:0] RA_MAGHI = 3'd3;
  localparam logic [2:0] RA_MAGLO = 3'd4;
  localparam logic [2:0] RA_PTR   = 3'd5;
  localparam logic [2:0] RA_DATA  = 3'd6;

  localparam logic [1:0] TS_EXT = 2'd0;
  localparam logic [1:0] TS_MAG = 2'd1;
  localparam logic [1:0] TS_SW  = 2'd2;

  localparam logic [1:0] SRC_PRE  = 2'd0;
  localparam logic [1:0] SRC_POST = 2'd1;
  localparam logic [1:0] SRC_MAG  = 2'd2;
endpackage

// File: rtl/cap_trigger.sv
module cap_trigger #(
  parameter int MAG_W = 16
) (
  input  logic [1:0]       tsel,
  input  logic             ext_trig,
  input  logic             sw_pulse,
  input  logic             smp_valid,
  input  logic [MAG_W-1:0] mag,
  input  logic [MAG_W-1:0] mag_hi,
  input  logic [MAG_W-1:0] mag_lo,
  output logic             hit
);
  import cap_pkg::*;
  logic out_of_window;

  always_comb begin
    out_of_window = smp_valid && ((mag > mag_hi) || (mag < mag_lo));
    case (tsel)
      TS_EXT:  hit = ext_trig;
      TS_MAG:  hit = out_of_window;
      TS_SW:   hit = sw_pulse;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_seq.sv
module cap_seq #(
  parameter int AW    = 11,
  parameter int DLY_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             arm_play,
  input  logic [DLY_W-1:0] delay,
  input  logic [AW-1:0]    last,
  input  logic             hit,
  input  logic             smp_valid,
  output logic             busy,
  output logic             cap_we,
  output logic             play_re,
  output logic [AW-1:0]    eng_addr,
  output logic             trig_pulse,
  output logic             done_pulse
);
  import cap_pkg::*;
  seq_state_t      state;
  logic [DLY_W-1:0] dcnt;

  assign busy     = (state != S_IDLE);
  assign cap_we   = (state == S_CAP) && smp_valid;
  assign play_re  = (state == S_PLAY);
  assign done_pulse = (cap_we || play_re) && (eng_addr == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      eng_addr   <= '0;
      dcnt       <= '0;
      trig_pulse <= 1'b0;
    end else begin
      trig_pulse <= 1'b0;
      case (state)
        S_IDLE: if (arm) begin
          eng_addr <= '0;
          dcnt     <= '0;
          state    <= arm_play ? S_PLAY : S_WAIT;
        end
        S_WAIT: if (hit) begin
          trig_pulse <= 1'b1;
          dcnt       <= '0;
          state      <= (delay == '0) ? S_CAP : S_DLY;
        end
        S_DLY: if (smp_valid) begin
          dcnt <= dcnt + DLY_W'(1);
          if (dcnt == delay - DLY_W'(1)) state <= S_CAP;
        end
        S_CAP: if (smp_valid) begin
          if (eng_addr == last) state <= S_IDLE;
          else eng_addr <= eng_addr + AW'(1);
        end
        S_PLAY: begin
          if (eng_addr == last) state <= S_IDLE;
          else eng_addr <= eng_addr + AW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int AW = 11,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/trig_capture_buf.sv
module trig_capture_buf #(
  parameter int DW    = 16,
  parameter int AW    = 11,
  parameter int DLY_W = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [DW-1:0] pre_i,
  input  logic [DW-1:0] pre_q,
  input  logic [DW-1:0] post_i,
  input  logic [DW-1:0] post_q,
  input  logic [DW-1:0] mag,
  input  logic          ext_trig,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          trig_out,
  output logic          play_valid,
  output logic [DW-1:0] play_i,
  output logic [DW-1:0] play_q
);
  import cap_pkg::*;
  localparam int MW = 2 * DW;

  logic             ctl_mode;
  logic [1:0]       ctl_src, ctl_tsel;
  logic [DLY_W-1:0] dly_q;
  logic [AW-1:0]    last_q, ptr_q, eng_addr;
  logic [DW-1:0]    hi_q, lo_q;
  logic             sw_q, done_q, rd_mem_q;
  logic [31:0]      rd_q;
  logic             busy, cap_we, play_re, done_pulse, hit, arm;
  logic             proc_wr, proc_rd;
  logic [MW-1:0]    cap_word, mem_q, mem_wdata;
  logic [AW-1:0]    mem_addr;
  logic             mem_en, mem_we;

  assign arm     = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0] && !busy;
  assign proc_wr = reg_wr && (reg_addr == RA_DATA) && !busy;
  assign proc_rd = reg_rd && !reg_wr && (reg_addr == RA_DATA) && !busy;

  cap_trigger #(.MAG_W(DW)) u_trig (
    .tsel(ctl_tsel), .ext_trig(ext_trig), .sw_pulse(sw_q),
    .smp_valid(smp_valid), .mag(mag), .mag_hi(hi_q), .mag_lo(lo_q),
    .hit(hit)
  );

  cap_seq #(.AW(AW), .DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst(rst), .arm(arm), .arm_play(reg_wdata[1]),
    .delay(dly_q), .last(last_q), .hit(hit), .smp_valid(smp_valid),
    .busy(busy), .cap_we(cap_we), .play_re(play_re), .eng_addr(eng_addr),
    .trig_pulse(trig_out), .done_pulse(done_pulse)
  );

  always_comb begin
    case (ctl_src)
      SRC_POST: cap_word = {post_q, post_i};
      SRC_MAG:  cap_word = {{DW{1'b0}}, mag};
      default:  cap_word = {pre_q, pre_i};
    endcase
    mem_en    = busy ? (cap_we || play_re) : (proc_wr || proc_rd);
    mem_we    = busy ? cap_we : proc_wr;
    mem_addr  = busy ? eng_addr : ptr_q;
    mem_wdata = busy ? cap_word : reg_wdata[MW-1:0];
  end

  cap_mem #(.AW(AW), .W(MW)) u_mem (
    .clk(clk), .en(mem_en), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_mode <= 1'b0; ctl_src <= '0; ctl_tsel <= '0;
      dly_q <= '0; last_q <= '0; hi_q <= '0; lo_q <= '0;
      ptr_q <= '0; sw_q <= 1'b0; done_q <= 1'b0;
      rd_q <= '0; rd_mem_q <= 1'b0; play_valid <= 1'b0;
    end else begin
      sw_q       <= 1'b0;
      play_valid <= play_re;
      rd_mem_q   <= proc_rd;
      if (reg_wr) begin
        case (reg_addr)
          RA_CTRL: begin
            ctl_mode <= reg_wdata[1];
            ctl_src  <= reg_wdata[3:2];
            ctl_tsel <= reg_wdata[5:4];
            sw_q     <= reg_wdata[6];
          end
          RA_DELAY: dly_q  <= reg_wdata[DLY_W-1:0];
          RA_LEN:   last_q <= reg_wdata[AW-1:0];
          RA_MAGHI: hi_q   <= reg_wdata[DW-1:0];
          RA_MAGLO: lo_q   <= reg_wdata[DW-1:0];
          RA_PTR:   ptr_q  <= reg_wdata[AW-1:0];
          default: ;
        endcase
      end
      if (proc_wr || proc_rd) ptr_q <= ptr_q + AW'(1);
      if (arm) done_q <= 1'b0;
      else if (done_pulse) done_q <= 1'b1;
      if (reg_rd) begin
        case (reg_addr)
          RA_CTRL:  rd_q <= {22'd0, busy, done_q, 2'b00, ctl_tsel, ctl_src, ctl_mode, 1'b0};
          RA_DELAY: rd_q <= 32'(dly_q);
          RA_LEN:   rd_q <= 32'(last_q);
          RA_MAGHI: rd_q <= 32'(hi_q);
          RA_MAGLO: rd_q <= 32'(lo_q);
          RA_PTR:   rd_q <= 32'(ptr_q);
          default:  rd_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata = rd_mem_q ? 32'(mem_q) : rd_q;
  assign play_i    = mem_q[DW-1:0];
  assign play_q    = mem_q[MW-1:DW];
endmodule

// File: rtl/cap_chk.sv
module cap_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic trig_out,
  input logic play_valid
);
  p_trig_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    trig_out |=> !trig_out);

  p_trig_while_armed_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_out) |-> $past(busy));

  p_arm_clears_done_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !done);

  p_done_after_finish_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !busy);

  p_play_from_busy_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(play_valid) |-> $past(busy));
endmodule

bind trig_capture_buf cap_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done_q),
  .trig_out(trig_out), .play_valid(play_valid)
);

// File: tb/test_trig_capture_buf.sv
module test_trig_capture_buf;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, smp_valid, ext_trig, reg_wr, reg_rd;
  logic [15:0] pre_i, pre_q, post_i, post_q, mag;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic trig_out, play_valid;
  logic [15:0] play_i, play_q;

  trig_capture_buf i_trig_capture_buf (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .pre_i(pre_i), .pre_q(pre_q),
    .post_i(post_i), .post_q(post_q), .mag(mag), .ext_trig(ext_trig),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trig_out(trig_out), .play_valid(play_valid),
    .play_i(play_i), .play_q(play_q)
  );

  int n_chk = 0, n_bad = 0, trig_cnt = 0, play_cnt = 0, sidx = 0;
  logic [31:0] exp_rd[$];
  logic [31:0] exp_play[$];
  logic rd_seen = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pre_w(input int k);
    return {16'h2000 + 16'(k), 16'h1000 + 16'(k)};
  endfunction
  function automatic logic [31:0] post_w(input int k);
    return {16'h4000 + 16'(k), 16'h3000 + 16'(k)};
  endfunction

  task automatic tick; @(posedge clk); #1; endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; tick; reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a; tick; reg_rd = 1'b0; d = reg_rdata;
  endtask

  // driver: push expected buffer word, then issue the data-register read
  task automatic rd_data(input logic [31:0] e);
    exp_rd.push_back(e);
    reg_rd = 1'b1; reg_addr = 3'd6; tick; reg_rd = 1'b0;
  endtask

  task automatic smp(input bit v, input bit t, input logic [15:0] m);
    smp_valid = v; ext_trig = t; mag = m;
    pre_i = 16'h1000 + 16'(sidx); pre_q = 16'h2000 + 16'(sidx);
    post_i = 16'h3000 + 16'(sidx); post_q = 16'h4000 + 16'(sidx);
    tick;
    if (v) sidx++;
    smp_valid = 1'b0; ext_trig = 1'b0;
  endtask

  // monitors
  always @(posedge clk) rd_seen <= reg_rd && !reg_wr && (reg_addr == 3'd6);
  always @(negedge clk) begin
    if (trig_out) trig_cnt++;
    if (rd_seen) begin
      if (exp_rd.size() == 0) chk("R2 unexpected read", reg_rdata, 32'hx);
      else chk("R2/R7 buffer read", reg_rdata, exp_rd.pop_front());
    end
    if (play_valid) begin
      play_cnt++;
      if (exp_play.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R11 extra play actual=%h expected=none", {play_q, play_i});
      end else chk("R11 playback", {play_q, play_i}, exp_play.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t, base;
    rst = 1'b1; smp_valid = 0; ext_trig = 0; reg_wr = 0; reg_rd = 0;
    reg_addr = 0; reg_wdata = 0; mag = 0;
    pre_i = 0; pre_q = 0; post_i = 0; post_q = 0;
    repeat (3) tick;
    rst = 1'b0; tick;
    // R1 reset state
    chk("R1 trig_out", 32'(trig_out), 0);
    chk("R1 play_valid", 32'(play_valid), 0);
    rd_reg(3'd0, d); chk("R1 ctrl", d, 0);
    rd_reg(3'd5, d); chk("R1 ptr", d, 0);

    // preload with marker pattern (R2)
    wr(3'd5, 0);
    for (int k = 0; k < 8; k++) wr(3'd6, 32'hA5A50000 + k);

    // capture 1: external trigger, delay 3, length 5, pre source
    wr(3'd1, 3); wr(3'd2, 4); wr(3'd0, 32'h1);
    rd_reg(3'd0, d); chk("R12 busy after arm", d, 32'h200);
    smp(1, 0, 500); smp(0, 0, 500); smp(1, 0, 500);
    chk("R3 no trigger without ext", 32'(trig_cnt), 0);
    t = sidx;
    smp(1, 1, 500);
    chk("R9 trig_out high", 32'(trig_out), 1);
    smp(1, 0, 500);
    chk("R9 trig_out low", 32'(trig_out), 0);
    smp(0, 0, 500); smp(1, 1, 500); smp(1, 0, 500);
    smp(1, 0, 500); smp(1, 0, 500); smp(0, 1, 500);
    smp(1, 1, 500); smp(1, 1, 500); smp(1, 1, 500);
    smp(1, 0, 500); smp(1, 0, 500); smp(1, 0, 500);
    chk("R10 single trigger", 32'(trig_cnt), 1);
    rd_reg(3'd0, d); chk("R12 done set", d, 32'h100);
    wr(3'd5, 0);
    for (int k = 0; k < 5; k++) rd_data(pre_w(t + 4 + k)); // R6 R7 R8
    rd_data(32'hA5A50005);                                  // R7 untouched
    rd_reg(3'd5, d); chk("R2 pointer advance", d, 6);

    // capture 2: magnitude below min, mag source, delay 0, length 3
    wr(3'd3, 1000); wr(3'd4, 100); wr(3'd1, 0); wr(3'd2, 2);
    wr(3'd0, 32'h19);
    base = trig_cnt;
    smp(1, 0, 500); smp(1, 1, 500); smp(0, 0, 50); smp(1, 0, 1000); smp(1, 0, 100);
    chk("R4 window quiet", 32'(trig_cnt), 32'(base));
    smp(1, 0, 50);
    smp(1, 0, 600); smp(1, 0, 700); smp(1, 0, 800); smp(1, 0, 900);
    chk("R4 below min fires", 32'(trig_cnt), 32'(base + 1));
    wr(3'd5, 0);
    rd_data(32'd600); rd_data(32'd700); rd_data(32'd800); // R8 magnitude

    // capture 3: magnitude above max, post source, delay 1, length 1
    wr(3'd1, 1); wr(3'd2, 0); wr(3'd0, 32'h15);
    base = trig_cnt;
    smp(1, 0, 999);
    chk("R4 inside max quiet", 32'(trig_cnt), 32'(base));
    t = sidx;
    smp(1, 0, 1001); smp(1, 0, 500); smp(1, 0, 500); smp(1, 0, 500);
    chk("R4 above max fires", 32'(trig_cnt), 32'(base + 1));
    wr(3'd5, 0);
    rd_data(post_w(t + 2)); rd_data(32'd700);

    // capture 4: software trigger, length 2
    wr(3'd1, 0); wr(3'd2, 1); wr(3'd0, 32'h21);
    base = trig_cnt;
    smp(1, 1, 2000);
    chk("R3 ext ignored under sw select", 32'(trig_cnt), 32'(base));
    wr(3'd0, 32'h60);
    rd_reg(3'd0, d); chk("R5 sw bit reads 0", d, 32'h220);
    chk("R5 sw trigger fires", 32'(trig_out), 1);
    t = sidx;
    smp(1, 0, 500); smp(1, 0, 500); smp(1, 0, 500);
    wr(3'd5, 0);
    rd_data(pre_w(t)); rd_data(pre_w(t + 1));

    // playback
    wr(3'd5, 0);
    for (int k = 0; k < 9; k++) wr(3'd6, 32'hC0DE0000 + 3 * k);
    for (int k = 0; k < 6; k++) exp_play.push_back(32'hC0DE0000 + 3 * k);
    play_cnt = 0;
    wr(3'd2, 5); wr(3'd0, 32'h3);
    wr(3'd6, 32'hDEADBEEF);            // R13 ignored while busy
    repeat (10) tick;
    chk("R11 play count", 32'(play_cnt), 6);
    chk("R11 queue drained", 32'(exp_play.size()), 0);
    rd_reg(3'd5, d); chk("R13 pointer held", d, 9);
    rd_reg(3'd0, d); chk("R12 done after play", d, 32'h102);
    wr(3'd5, 8); rd_data(32'hC0DE0018); // R13 entry intact

    // pointer wrap R2
    wr(3'd5, 2047); wr(3'd6, 32'h11111111); wr(3'd6, 32'h22222222);
    rd_reg(3'd5, d); chk("R2 wrap", d, 1);
    wr(3'd5, 2047); rd_data(32'h11111111); rd_data(32'h22222222);

    repeat (4) tick;
    chk("R2 read queue drained", 32'(exp_rd.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule